// File: doc/BRIEF.md
# Pipelined Truncated Squarer

This unit squares a 15-bit unsigned operand and delivers only the upper 16 bits of the 30-bit square. It does not form the full square and then cut it. Instead, every partial product that lands in one of the eleven least significant columns is discarded before any addition. A fixed compensation constant stands in for the average weight of the discarded columns. The returned value therefore stays within one LSB of the exactly truncated square, and the adders are narrower and shallower than a full-precision squarer would need.

The operand is read as a fraction with fifteen fractional bits. The result is read as a fraction with sixteen fractional bits, so the result approximates operand²/2¹⁴. The work is spread over four register stages, and a new operand may be presented on every clock. A single valid flag travels alongside the data. This suits the unit for phase-to-amplitude polynomial evaluation in a frequency synthesizer, where squares of phase words are needed at full sample rate.

Top module: `trunc_squarer`

## Requirements
- R1: For every operand x in 0..32767, the result differs by at most 1 from floor(x·x / 16384).
- R2: The result is exactly floor((x·x − D(x) + 5120) / 16384). D(x) is the weight of all dropped terms. Each operand bit x_i contributes 2^(2i) to D when 2i < 11. Each pair x_i·x_j with i < j contributes 2^(i+j+1) to D when i+j+1 < 11.
- R3: When valid_in is high on the clock edge that captures x, valid_out goes high four clock edges later, carrying the result for x. valid_out is low four edges after a capture with valid_in low.
- R4: While valid_out is low, result keeps its last value, and operand changes with valid_in low have no effect on it.
- R5: A synchronous reset (rst high on a clock edge) clears valid_out and result to 0 and discards operands already in flight.
- R6: Operand 0 gives result 0. Operand 32767 gives result 65531. No internal sum overflows the 30-bit square range.
- R7: Operands presented on consecutive cycles each produce exactly one result, with no stall, in order of arrival.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| valid_in | input | 1 | Operand qualifier |
| operand | input | 15 | Unsigned operand, 15 fractional bits |
| valid_out | output | 1 | Result qualifier, valid_in delayed four cycles |
| result | output | 16 | Truncated square, 16 fractional bits |

## Verification
The hardest cases to reach from the ports are the operands where the compensated sum sits right next to a multiple of 2¹⁴. Only there does the compensation constant decide whether the result equals the exact truncation or misses it by one. These operands are scattered irregularly, so no short directed list hits them. The stimulus therefore streams all 32768 operands back to back, which also keeps every pipeline stage full on every cycle. Each output is compared bit for bit against an independently computed dropped-term model and against the exact truncation within one LSB. A reset asserted while operands are in flight covers the flush case.

// File: rtl/trunc_sq_pkg.sv
package trunc_sq_pkg;

  localparam int unsigned TSQ_IN_W     = 15;
  localparam int unsigned TSQ_OUT_W    = 16;
  localparam int unsigned TSQ_KEEP_LSB = 11;
  localparam int unsigned TSQ_GROUP    = 4;

  // Kept part of one squarer row: the diagonal bit x_i at weight 2^(2i)
  // plus every doubled cross term x_i*x_j (j>i) at weight 2^(i+j+1),
  // with all columns below keep_lsb forced to zero.
  function automatic logic [63:0] tsq_row(logic [63:0] x, int unsigned i,
                                          int unsigned n, int unsigned keep_lsb);
    logic [63:0] acc;
    acc = '0;
    if (x[i]) begin
      acc = 64'd1 << (2 * i);
      for (int unsigned j = i + 1; j < n; j++) begin
        if (x[j]) acc = acc + (64'd1 << (i + j + 1));
      end
    end
    acc = acc & ~((64'd1 << keep_lsb) - 64'd1);
    return acc;
  endfunction

  // Largest total weight the dropped columns can carry.
  function automatic longint unsigned tsq_drop_max(int unsigned n, int unsigned keep_lsb);
    longint unsigned s;
    s = 0;
    for (int unsigned i = 0; i < n; i++) begin
      if (2 * i < keep_lsb) s = s + (longint'(1) << (2 * i));
      for (int unsigned j = i + 1; j < n; j++) begin
        if (i + j + 1 < keep_lsb) s = s + (longint'(1) << (i + j + 1));
      end
    end
    return s;
  endfunction

  // Compensation: half the worst-case dropped weight, centring the error.
  function automatic longint unsigned tsq_comp(int unsigned n, int unsigned keep_lsb);
    return tsq_drop_max(n, keep_lsb) / 2;
  endfunction

endpackage

// File: rtl/trunc_sq_pp.sv
module trunc_sq_pp
  import trunc_sq_pkg::*;
#(
  parameter int unsigned IN_W     = TSQ_IN_W,
  parameter int unsigned KEEP_LSB = TSQ_KEEP_LSB,
  localparam int unsigned SQ_W    = 2 * IN_W,
  localparam int unsigned ACC_W   = SQ_W + 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        valid_in,
  input  logic [IN_W-1:0]             operand,
  output logic                        valid_q,
  output logic [IN_W-1:0][ACC_W-1:0]  rows_q
);

  localparam longint unsigned DROP_MAX = tsq_drop_max(IN_W, KEEP_LSB);

  logic [IN_W-1:0][ACC_W-1:0] rows_d;
  logic [63:0]                chk_kept;
  logic [63:0]                chk_exact;

  always_comb begin
    for (int unsigned i = 0; i < IN_W; i++) begin
      rows_d[i] = ACC_W'(tsq_row(64'(operand), i, IN_W, KEEP_LSB));
    end
  end

  // Named observation wires: sum of kept rows and the exact square.
  always_comb begin
    chk_kept = '0;
    for (int unsigned i = 0; i < IN_W; i++) chk_kept = chk_kept + 64'(rows_d[i]);
    chk_exact = 64'(operand) * 64'(operand);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      rows_q  <= '0;
    end else begin
      valid_q <= valid_in;
      if (valid_in) rows_q <= rows_d;
    end
  end

  // R2: the dropped weight is never negative and never above its bound.
  always_ff @(posedge clk) begin
    if (!rst && valid_in) begin
      p_drop_bound_r2: assert (chk_kept <= chk_exact && (chk_exact - chk_kept) <= DROP_MAX);
    end
  end

endmodule

// File: rtl/trunc_sq_sum.sv
module trunc_sq_sum
  import trunc_sq_pkg::*;
#(
  parameter int unsigned IN_W     = TSQ_IN_W,
  parameter int unsigned OUT_W    = TSQ_OUT_W,
  parameter int unsigned KEEP_LSB = TSQ_KEEP_LSB,
  parameter int unsigned GROUP    = TSQ_GROUP,
  localparam int unsigned SQ_W    = 2 * IN_W,
  localparam int unsigned ACC_W   = SQ_W + 1,
  localparam int unsigned SHIFT   = SQ_W - OUT_W,
  localparam int unsigned NGRP    = (IN_W + GROUP - 1) / GROUP
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        valid_in,
  input  logic [IN_W-1:0][ACC_W-1:0]  rows,
  output logic                        valid_q,
  output logic [OUT_W-1:0]            sum_hi_q
);

  localparam logic [ACC_W-1:0] COMP = ACC_W'(tsq_comp(IN_W, KEEP_LSB));

  logic                        v_grp;
  logic [NGRP-1:0][ACC_W-1:0]  grp_q;
  logic [ACC_W-1:0]            total_d;

  // Stage 2: rows reduced in groups.
  for (genvar g = 0; g < NGRP; g++) begin : g_group
    localparam int unsigned LO = g * GROUP;
    localparam int unsigned HI = ((g + 1) * GROUP < IN_W) ? (g + 1) * GROUP : IN_W;
    logic [ACC_W-1:0] grp_d;
    always_comb begin
      grp_d = '0;
      for (int unsigned r = LO; r < HI; r++) grp_d = grp_d + rows[r];
    end
    always_ff @(posedge clk) begin
      if (rst) grp_q[g] <= '0;
      else if (valid_in) grp_q[g] <= grp_d;
    end
  end

  // Stage 3: group sums plus the compensation constant.
  always_comb begin
    total_d = COMP;
    for (int unsigned g = 0; g < NGRP; g++) total_d = total_d + grp_q[g];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v_grp    <= 1'b0;
      valid_q  <= 1'b0;
      sum_hi_q <= '0;
    end else begin
      v_grp   <= valid_in;
      valid_q <= v_grp;
      if (v_grp) sum_hi_q <= total_d[SHIFT +: OUT_W];
    end
  end

  // R6: the compensated sum stays inside the square's range.
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
    v_grp |-> (total_d < (ACC_W'(1) << SQ_W)));

endmodule

// File: rtl/trunc_squarer.sv
module trunc_squarer
  import trunc_sq_pkg::*;
#(
  parameter int unsigned IN_W     = TSQ_IN_W,
  parameter int unsigned OUT_W    = TSQ_OUT_W,
  parameter int unsigned KEEP_LSB = TSQ_KEEP_LSB,
  parameter int unsigned GROUP    = TSQ_GROUP
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             valid_in,
  input  logic [IN_W-1:0]  operand,
  output logic             valid_out,
  output logic [OUT_W-1:0] result
);

  localparam int unsigned SQ_W  = 2 * IN_W;
  localparam int unsigned ACC_W = SQ_W + 1;

  logic                        v_pp;
  logic [IN_W-1:0][ACC_W-1:0]  rows_pp;
  logic                        v_sum;
  logic [OUT_W-1:0]            sum_hi;
  logic                        v_out_q;
  logic [OUT_W-1:0]            res_q;

  trunc_sq_pp #(
    .IN_W     (IN_W),
    .KEEP_LSB (KEEP_LSB)
  ) u_pp (
    .clk      (clk),
    .rst      (rst),
    .valid_in (valid_in),
    .operand  (operand),
    .valid_q  (v_pp),
    .rows_q   (rows_pp)
  );

  trunc_sq_sum #(
    .IN_W     (IN_W),
    .OUT_W    (OUT_W),
    .KEEP_LSB (KEEP_LSB),
    .GROUP    (GROUP)
  ) u_sum (
    .clk      (clk),
    .rst      (rst),
    .valid_in (v_pp),
    .rows     (rows_pp),
    .valid_q  (v_sum),
    .sum_hi_q (sum_hi)
  );

  // Stage 4: output register, loaded only with a valid result.
  always_ff @(posedge clk) begin
    if (rst) begin
      v_out_q <= 1'b0;
      res_q   <= '0;
    end else begin
      v_out_q <= v_sum;
      if (v_sum) res_q <= sum_hi;
    end
  end

  assign valid_out = v_out_q;
  assign result    = res_q;

  p_latency_r3: assert property (@(posedge clk) disable iff (rst)
    valid_in |-> ##4 valid_out);

  p_idle_r3: assert property (@(posedge clk) disable iff (rst)
    !valid_in |-> ##4 !valid_out);

  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!valid_out && !$past(rst)) |-> $stable(result));

  p_reset_r5: assert property (@(posedge clk)
    rst |=> (!valid_out && result == '0));

  p_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (valid_in && operand == '0) |-> ##4 (result == '0));

endmodule

// File: tb/trunc_squarer_test.sv
`timescale 1ns/1ps
module trunc_squarer_test;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 9;
  localparam logic [14:0] VX   [NVEC] = '{15'd0, 15'd1, 15'd128, 15'd181, 15'd1000,
                                          15'd12345, 15'd16384, 15'd20000, 15'd32767};
  localparam int          VEXP [NVEC] = '{0, 0, 1, 1, 61, 9301, 16384, 24414, 65532};

  typedef struct { int x; int c; } ent_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        valid_in = 1'b0;
  logic [14:0] operand = '0;
  logic        valid_out;
  logic [15:0] result;

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;
  int outs = 0;
  ent_t pend[$];

  trunc_squarer uut (
    .clk       (clk),
    .rst       (rst),
    .valid_in  (valid_in),
    .operand   (operand),
    .valid_out (valid_out),
    .result    (result)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic longint exact_trunc(longint x);
    return (x * x) >> 14;
  endfunction

  // Dropped-term model written from R2.
  function automatic longint model_trunc(longint x);
    longint d = 0;
    for (int i = 0; i < 15; i++) begin
      if (x[i]) begin
        if (2 * i < 11) d += longint'(1) << (2 * i);
        for (int j = i + 1; j < 15; j++)
          if (x[j] && (i + j + 1) < 11) d += longint'(1) << (i + j + 1);
      end
    end
    return (x * x - d + 5120) >> 14;
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic observe();
    ent_t e;
    if (valid_out) begin
      if (pend.size() == 0) begin
        check(1'b0, "R3 unexpected valid_out", 1, 0);
      end else begin
        e = pend.pop_front();
        outs++;
        check(cyc - e.c == 4, "R3 latency", cyc - e.c, 4);
        check(model_trunc(e.x) == longint'(result), "R2 bit-exact", result, model_trunc(e.x));
        check((longint'(result) - exact_trunc(e.x) <= 1) && (exact_trunc(e.x) - longint'(result) <= 1),
              "R1 within one LSB", result, exact_trunc(e.x));
      end
    end else if (pend.size() != 0 && (cyc - pend[0].c) >= 4) begin
      check(1'b0, "R3 missing valid_out", 0, 1);
      void'(pend.pop_front());
    end
  endtask

  task automatic cycle(bit v, logic [14:0] x);
    ent_t e;
    valid_in = v;
    operand  = x;
    if (v) begin
      e.x = int'(x);
      e.c = cyc;
      pend.push_back(e);
    end
    @(posedge clk);
    cyc++;
    @(negedge clk);
    observe();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    // R5: reset state
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(valid_out == 1'b0, "R5 reset valid_out", valid_out, 0);
    check(result == 16'd0, "R5 reset result", result, 0);
    rst = 1'b0;

    // R1/R2/R3: vector table, one operand at a time
    for (int i = 0; i < NVEC; i++) begin
      cycle(1'b1, VX[i]);
      repeat (4) cycle(1'b0, 15'd0);
      check((int'(result) - VEXP[i] <= 1) && (VEXP[i] - int'(result) <= 1),
            "R1 table", result, VEXP[i]);
    end

    // R6: end points
    cycle(1'b1, 15'd0);
    repeat (4) cycle(1'b0, 15'h7fff);
    check(result == 16'd0, "R6 zero operand", result, 0);
    cycle(1'b1, 15'd32767);
    repeat (4) cycle(1'b0, 15'd0);
    check(result == 16'd65531, "R6 full-scale operand", result, 65531);

    // R4: operand changes without valid_in leave the output alone
    for (int k = 0; k < 6; k++) begin
      cycle(1'b0, 15'(k * 4099 + 7));
      check(valid_out == 1'b0, "R4 no valid_out", valid_out, 0);
      check(result == 16'd65531, "R4 result held", result, 65531);
    end

    // R7: exhaustive back-to-back stream
    outs = 0;
    for (int k = 0; k < 32768; k++) cycle(1'b1, 15'(k));
    repeat (5) cycle(1'b0, 15'd0);
    check(outs == 32768, "R7 one result per operand", outs, 32768);
    check(pend.size() == 0, "R7 nothing left in flight", pend.size(), 0);

    // R5: reset with operands in flight
    cycle(1'b1, 15'd100);
    cycle(1'b1, 15'd200);
    valid_in = 1'b0;
    rst = 1'b1;
    pend.delete();
    repeat (2) @(posedge clk);
    cyc += 2;
    @(negedge clk);
    check(valid_out == 1'b0, "R5 flush valid_out", valid_out, 0);
    check(result == 16'd0, "R5 flush result", result, 0);
    rst = 1'b0;
    for (int k = 0; k < 5; k++) begin
      cycle(1'b0, 15'd0);
      check(valid_out == 1'b0, "R5 flushed operand stays gone", valid_out, 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule